// File: doc/BRIEF.md
# Configurable-Polarity PWM Generator

This block produces a pulse-width-modulated waveform from two 8-bit settings: an on-time value and a period value. A phase counter advances once for each clock-enable tick from an upstream frequency selector. The on-time phase always comes first in a period and lasts on-time + 1 ticks. The whole period lasts period + 1 ticks, so the duty cycle is (on-time + 1)/(period + 1).

Each of several outputs has its own polarity bit, which decides whether that output's active phase is a logic high or a logic low. An enable input forces every output to its inactive level and holds the phase counter at zero, so the first period after enabling starts cleanly with the active phase. The settings pass through shadow registers that are reloaded only at a period boundary, or at any time while the block is disabled. A change made in the middle of a period therefore never produces a truncated or stretched cycle.

Top module: `pwm_polar_gen`

## Requirements
- R1: While enabled with an on-time value H (nonzero) and a period value P, where H < P, the phase counter runs 0..P, one step per tick. Phase k is active exactly when k <= H, so each period has H+1 active ticks out of P+1.
- R2: With H = 127 and P = 255, exactly 128 of every 256 ticks are active (50% duty).
- R3: When H >= P and P > 0, the output stays active for every phase (100% duty).
- R4: When H = 0, the output stays inactive for every phase, whatever P is. This includes H = P = 0.
- R5: Clearing `en` drives every output to its inactive level in the same cycle and holds the phase counter at 0. After `en` is set again, the first tick-interval is phase 0.
- R6: For each output i, `pol[i]` = 1 makes the active level 1 and the inactive level 0. `pol[i]` = 0 makes the active level 0 and the inactive level 1.
- R7: The phase counter advances only on a clock edge where `tick` = 1. While `tick` = 0, the phase and the outputs hold.
- R8: New `high_val`/`period_val` values take effect only from the start of the period that follows the next wrap (phase P with a tick). A change presented in the wrap cycle itself takes effect in the very next period.
- R9: After synchronous reset, the shadow on-time and period are 0 and the phase is 0, so the outputs sit at their inactive level until new values are loaded at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock-enable from the frequency selector; one phase step per tick |
| en | input | 1 | Block enable; 0 forces outputs inactive and holds the counter |
| high_val | input | CNT_W | On-time setting H |
| period_val | input | CNT_W | Period setting P |
| pol | input | N_OUT | Per-output polarity; 1 = active high |
| pwm_out | output | N_OUT | PWM outputs |

## Verification
Two events can fall in the same clock: a settings change and the period wrap that reloads the shadow registers. The bench presents new on-time and period values while the counter sits at its last phase, so that the wrap edge itself samples them. It then checks every phase of the following periods against the new values and the remaining phases of the old period against the old ones. A second collision, disable arriving mid-period, is judged by checking that the output drops in that cycle and that re-enabling starts at phase 0.

// File: rtl/pwm_polar_pkg.sv
package pwm_polar_pkg;

  // Forced-off rule: a zero on-time wins over everything else.
  function automatic logic duty_zero(input int unsigned hi);
    return (hi == 0);
  endfunction

  // Forced-on rule: on-time reaches a nonzero period.
  function automatic logic duty_full(input int unsigned hi, input int unsigned per);
    return (per != 0) && (hi >= per);
  endfunction

  // Active phase decision for one counter value.
  function automatic logic phase_active(input int unsigned ph,
                                        input int unsigned hi,
                                        input int unsigned per);
    if (duty_zero(hi))          return 1'b0;
    else if (duty_full(hi, per)) return 1'b1;
    else                        return (ph <= hi);
  endfunction

endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] high_in,
  input  logic [CNT_W-1:0] per_in,
  output logic [CNT_W-1:0] high_q,
  output logic [CNT_W-1:0] per_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      high_q <= '0;
      per_q  <= '0;
    end else if (load) begin
      high_q <= high_in;
      per_q  <= per_in;
    end
  end
endmodule

// File: rtl/pwm_phase_cnt.sv
module pwm_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  assign wrap = en && tick && (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (!en)  cnt_q <= '0;
    else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int N_OUT = 2
) (
  input  logic             act,
  input  logic [N_OUT-1:0] pol,
  output logic [N_OUT-1:0] pwm_out
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    assign pwm_out[i] = pol[i] ? act : ~act;
  end
endmodule

// File: rtl/pwm_polar_gen.sv
module pwm_polar_gen
  import pwm_polar_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic [CNT_W-1:0] high_val,
  input  logic [CNT_W-1:0] period_val,
  input  logic [N_OUT-1:0] pol,
  output logic [N_OUT-1:0] pwm_out
);
  logic [CNT_W-1:0] sh_high;
  logic [CNT_W-1:0] sh_per;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_evt;
  logic             load_evt;
  logic             act;

  // Shadow reload: at each wrap, or continuously while disabled.
  assign load_evt = !en || wrap_evt;

  pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .load(load_evt),
    .high_in(high_val), .per_in(period_val),
    .high_q(sh_high), .per_q(sh_per)
  );

  pwm_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .per_q(sh_per), .cnt_q(cnt_q), .wrap(wrap_evt)
  );

  assign act = en && phase_active(32'(cnt_q), 32'(sh_high), 32'(sh_per));

  pwm_out_stage #(.N_OUT(N_OUT)) u_out (
    .act(act), .pol(pol), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_polar_gen_chk.sv
module pwm_polar_gen_chk #(
  parameter int CNT_W = 8,
  parameter int N_OUT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             tick,
  input logic [N_OUT-1:0] pol,
  input logic [N_OUT-1:0] pwm_out,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] sh_high,
  input logic [CNT_W-1:0] sh_per,
  input logic             load_evt,
  input logic             wrap_evt
);
  // R1: the phase never passes the latched period
  assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= sh_per);

  // R1: a wrap returns the phase to zero
  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (cnt_q == '0));

  // R3: forced-on when on-time reaches a nonzero period
  assert_full_duty_R3: assert property (@(posedge clk) disable iff (rst)
    (en && sh_per != '0 && sh_high >= sh_per) |-> (pwm_out == pol));

  // R4: zero on-time keeps outputs inactive
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (sh_high == '0) |-> (pwm_out == ~pol));

  // R5: disable forces inactive and clears the phase
  assert_disable_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !en |-> (pwm_out == ~pol));
  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));

  // R7: no tick, no movement
  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_q));

  // R8: shadow values change only after a load event
  assert_shadow_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !($stable(sh_high) && $stable(sh_per)) |-> $past(load_evt));
endmodule

bind pwm_polar_gen pwm_polar_gen_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick), .pol(pol), .pwm_out(pwm_out),
  .cnt_q(cnt_q), .sh_high(sh_high), .sh_per(sh_per),
  .load_evt(load_evt), .wrap_evt(wrap_evt)
);

// File: tb/sim_pwm_polar_gen.sv
`timescale 1ns/1ps
module sim_pwm_polar_gen;
  localparam int CNT_W = 8;
  localparam int N_OUT = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tick = 1'b0;
  logic             en = 1'b1;
  logic [CNT_W-1:0] high_val = 8'h55;
  logic [CNT_W-1:0] period_val = 8'h80;
  logic [N_OUT-1:0] pol = 2'b10;
  logic [N_OUT-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwm_polar_gen #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .en(en),
    .high_val(high_val), .period_val(period_val),
    .pol(pol), .pwm_out(pwm_out)
  );

  // Reference rule, written independently from the requirements.
  function automatic bit ref_on(int ph, int h, int p);
    if (h == 0) return 1'b0;
    if (p > 0 && h >= p) return 1'b1;
    return ph <= h;
  endfunction

  task automatic check_out(input bit exp_act, input string req);
    logic [N_OUT-1:0] expv;
    expv = exp_act ? pol : ~pol;
    checks++;
    if (pwm_out !== expv) begin
      errors++;
      $display("FAIL %s: pwm_out=%b expected %b (h=%0d p=%0d pol=%b)",
               req, pwm_out, expv, high_val, period_val, pol);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Disable, load settings, enable at phase 0.
  task automatic start(input int h, input int p, input logic [N_OUT-1:0] pv);
    step();
    en = 1'b0; tick = 1'b1;
    high_val = CNT_W'(h); period_val = CNT_W'(p); pol = pv;
    step();
    en = 1'b1;
  endtask

  task automatic run_combo(input int h, input int p, input logic [N_OUT-1:0] pv,
                           input string req);
    int ons;
    ons = 0;
    start(h, p, pv);
    for (int k = 0; k < 2 * (p + 1); k++) begin
      @(negedge clk);
      if (k <= p && pwm_out == pol) ons++;
      check_out(ref_on(k % (p + 1), h, p), req);
    end
    checks++;
    begin
      int want;
      want = (h == 0) ? 0 : (((h < p) ? h : p) + 1);
      if (h != 0 && p == 0) want = 1;
      if (ons != want) begin
        errors++;
        $display("FAIL %s: active ticks=%0d expected %0d (h=%0d p=%0d)", req, ons, want, h, p);
      end
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_out(1'b0, "R9 reset inactive");
    @(negedge clk);
    check_out(1'b0, "R9 reset inactive, no tick");

    // R1/R3/R4/R6: sweep of small settings, alternating polarity
    for (int p = 0; p < 10; p++)
      for (int h = 0; h < 12; h++)
        run_combo(h, p, 2'((h + p) % 4),
                  (h == 0) ? "R4 zero duty" :
                  (p > 0 && h >= p) ? "R3 full duty" : "R1 R6 duty sweep");

    // R2: 50% and neighbours at full width
    run_combo(127, 255, 2'b10, "R2 half duty");
    run_combo(254, 255, 2'b01, "R1 near full");
    run_combo(255, 255, 2'b11, "R3 full at max");
    run_combo(0, 255, 2'b00, "R4 zero at max");
    run_combo(0, 0, 2'b10, "R4 both zero");

    // R7: ticks withheld
    start(4, 9, 2'b10);
    repeat (5) @(negedge clk);          // phase 4
    tick = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_out(1'b1, "R7 hold at phase 4");
    end
    tick = 1'b1;
    @(negedge clk);
    check_out(1'b0, "R7 resume to phase 5");

    // R8: mid-period change waits for the wrap
    start(4, 9, 2'b01);
    repeat (3) @(negedge clk);          // phase 2
    high_val = 8'd1; period_val = 8'd3;
    for (int k = 3; k <= 9; k++) begin
      @(negedge clk);
      check_out(ref_on(k, 4, 9), "R8 old values kept");
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check_out(ref_on(k % 4, 1, 3), "R8 new values used");
    end

    // R8: change presented in the wrap cycle
    start(2, 5, 2'b10);
    repeat (6) @(negedge clk);          // phase 5, the wrap cycle
    high_val = 8'd5; period_val = 8'd7;
    check_out(1'b0, "R8 wrap cycle old");
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check_out(ref_on(k % 8, 5, 7), "R8 wrap-cycle update");
    end

    // R5: disable mid-period, re-enable at phase 0
    start(6, 9, 2'b10);
    repeat (4) @(negedge clk);          // phase 3
    en = 1'b0; #1;
    check_out(1'b0, "R5 disable immediate");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_out(1'b0, "R5 disabled hold");
    end
    en = 1'b1; #1;
    check_out(1'b1, "R5 restart phase 0");
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      check_out(ref_on(k, 6, 9), "R5 restart sequence");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule